// File: doc/BRIEF.md
# Memory-Mapped Device Ready/Data Port

This block connects one byte-wide peripheral to a simple processor load/store bus. It claims a reserved window at the top of the address space and serves two registers inside it. The status/control register holds a ready flag and an interrupt-enable bit. The data register holds the byte being moved between the processor and the device.

The device raises the ready flag with a one-cycle strobe. With the same strobe it can also load a byte that it is supplying. Any processor load or store to the data register clears the flag, and the device gets a one-cycle acknowledge pulse for that access. Software can poll the status register, since reading it changes nothing. It can also set the enable bit, so that an interrupt request is held high for as long as the flag is set. One flag therefore serves both the polled style of transfer and the interrupt-driven style.

Bus reads are combinational. Read data is valid in the same cycle as the request, and writes take effect at the next clock edge.

Top module: `mmio_dev_port`

## Requirements
- R1: `busHit` is high exactly when `busRead` or `busWrite` is high and `busAddr[31:16]` equals 0xFFFF. Outside the window `busRdata` is zero and no register changes.
- R2: A read at window offset 0x0000 returns the ready flag in bit 0 and the interrupt-enable bit in bit 1, with all other bits zero. The read leaves both bits unchanged.
- R3: A high `devSet` sets the ready flag at the next clock edge.
- R4: A read or a write at offset 0x0004 clears the ready flag at the next edge. In the same cycle it pulses `devTaken`.
- R5: When `devSet` is high in the same cycle as an access at offset 0x0004, the ready flag stays set.
- R6: A write at offset 0x0000 copies `busWdata[1]` into the interrupt-enable bit. `busWdata[0]` is ignored, so the ready flag cannot be written by the processor.
- R7: `irqReq` is high exactly when both the ready flag and the interrupt-enable bit are high.
- R8: The data register loads `devByteIn` when `devSet` and `devLoad` are both high. Otherwise it loads `busWdata[7:0]` on a write at offset 0x0004, so the device load wins when both happen in one cycle. A read at 0x0004 returns the byte zero-extended, and `devByteOut` always shows it.
- R9: Window offsets other than 0x0000 and 0x0004 are still claimed. Reads there return zero and writes there change nothing.
- R10: With `rstN` low, the ready flag, the interrupt-enable bit and the data register are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the bus access |
| busRead | input | 1 | Load request this cycle |
| busWrite | input | 1 | Store request this cycle |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, combinational, zero unless a register is read |
| busHit | output | 1 | The port claims the current access |
| devSet | input | 1 | Device strobe that raises the ready flag |
| devLoad | input | 1 | With devSet, also load devByteIn into the data register |
| devByteIn | input | 8 | Byte offered by the device |
| devByteOut | output | 8 | Current contents of the data register |
| devTaken | output | 1 | Pulse for a processor access to the data register |
| irqReq | output | 1 | Interrupt request (ready AND enable) |

## Verification
The assertions assume that `busRead` and `busWrite` are never high in the same cycle, and that `devLoad` has meaning only while `devSet` is high. The random stimulus picks idle, read or write for each cycle, so the two bus strobes never overlap. Addresses are drawn mostly from the two register offsets, an unused window offset and an address just below the window, with a few fully random addresses mixed in. Device strobes are random and independent of the bus. This makes collisions between `devSet` and a data-register access occur often.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;
  typedef struct packed {
    logic hit;
    logic rdCtrl;
    logic wrCtrl;
    logic rdData;
    logic wrData;
  } portStrobe_t;
endpackage

// File: rtl/mmio_port_ctrl.sv
module mmio_port_ctrl
  import mmio_port_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = '1,
  parameter logic [WIN_BITS-1:0] OFF_CTRL = 'h0,
  parameter logic [WIN_BITS-1:0] OFF_DATA = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              wrEnBit,
  input  logic              devSet,
  output portStrobe_t       strobe,
  output logic              ready,
  output logic              irqEn,
  output logic              irqReq,
  output logic              devTaken
);
  logic inWindow;
  logic [WIN_BITS-1:0] offset;
  logic dataAccess;

  assign inWindow = (busAddr[ADDR_W-1:WIN_BITS] == WIN_TAG);
  assign offset   = busAddr[WIN_BITS-1:0];

  always_comb begin
    strobe.hit    = inWindow && (busRead || busWrite);
    strobe.rdCtrl = strobe.hit && busRead  && (offset == OFF_CTRL);
    strobe.wrCtrl = strobe.hit && busWrite && (offset == OFF_CTRL);
    strobe.rdData = strobe.hit && busRead  && (offset == OFF_DATA);
    strobe.wrData = strobe.hit && busWrite && (offset == OFF_DATA);
  end

  assign dataAccess = strobe.rdData || strobe.wrData;
  assign devTaken   = dataAccess;

  // Device strobe wins over the clearing access so no event is lost.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (devSet)          ready <= 1'b1;
      else if (dataAccess) ready <= 1'b0;
      if (strobe.wrCtrl)   irqEn <= wrEnBit;
    end
  end

  assign irqReq = ready && irqEn;

  // R3 / R5
  a_r3_set_ready: assert property (@(posedge clk) disable iff (!rstN)
    devSet |=> ready);
  // R4
  a_r4_access_clears: assert property (@(posedge clk) disable iff (!rstN)
    (devTaken && !devSet) |=> !ready);
  // R2
  a_r2_status_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdCtrl && !devSet) |=> (ready == $past(ready) && $stable(irqEn)));
  // R6
  a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrl |=> $stable(irqEn));
  // Bus strobes are one-hot at most
  a_r1_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdCtrl, strobe.wrCtrl, strobe.rdData, strobe.wrData}));
endmodule

// File: rtl/mmio_port_dpath.sv
module mmio_port_dpath
  import mmio_port_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              devSet,
  input  logic              devLoad,
  input  logic [BYTE_W-1:0] devByteIn,
  input  logic              ready,
  input  logic              irqEn,
  output logic [BUS_W-1:0]  busRdata,
  output logic [BYTE_W-1:0] devByteOut
);
  logic [BYTE_W-1:0] dataReg;
  logic devWrite;

  assign devWrite = devSet && devLoad;

  always_ff @(posedge clk) begin
    if (!rstN)              dataReg <= '0;
    else if (devWrite)      dataReg <= devByteIn;
    else if (strobe.wrData) dataReg <= wrByte;
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rdCtrl)      busRdata[1:0] = {irqEn, ready};
    else if (strobe.rdData) busRdata[BYTE_W-1:0] = dataReg;
  end

  assign devByteOut = dataReg;

  // R8: register changes only on a device load or a processor store
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!devWrite && !strobe.wrData) |=> $stable(dataReg));
  // R8: device load wins
  a_r8_dev_priority: assert property (@(posedge clk) disable iff (!rstN)
    devWrite |=> (dataReg == $past(devByteIn)));
  // R9: unclaimed or unused offsets read zero
  a_r9_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdCtrl || strobe.rdData) |-> (busRdata == '0));
endmodule

// File: rtl/mmio_dev_port.sv
module mmio_dev_port
  import mmio_port_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BUS_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int WIN_BITS = 16,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busHit,
  input  logic              devSet,
  input  logic              devLoad,
  input  logic [BYTE_W-1:0] devByteIn,
  output logic [BYTE_W-1:0] devByteOut,
  output logic              devTaken,
  output logic              irqReq
);
  portStrobe_t strobe;
  logic ready;
  logic irqEn;

  mmio_port_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)
  ) ctrlU (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .wrEnBit(busWdata[1]), .devSet(devSet),
    .strobe(strobe), .ready(ready), .irqEn(irqEn), .irqReq(irqReq),
    .devTaken(devTaken)
  );

  mmio_port_dpath #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) dpathU (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(busWdata[BYTE_W-1:0]),
    .devSet(devSet), .devLoad(devLoad), .devByteIn(devByteIn),
    .ready(ready), .irqEn(irqEn), .busRdata(busRdata), .devByteOut(devByteOut)
  );

  assign busHit = strobe.hit;

  // R1: nothing below the window is claimed
  a_r1_no_claim_outside: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:WIN_BITS] != WIN_TAG) |-> (!busHit && busRdata == '0 && !devTaken));
  // R7
  a_r7_irq_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (busRead && busAddr == {WIN_TAG, {WIN_BITS{1'b0}}}) ? (busRdata[1:0] == 2'b11) : 1'b1);
  // R10
  a_r10_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!irqReq && devByteOut == '0));
endmodule

// File: tb/mmio_dev_port_test.sv
module mmio_dev_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] busAddr;
  logic        busRead, busWrite;
  logic [31:0] busWdata, busRdata;
  logic        busHit;
  logic        devSet, devLoad;
  logic [7:0]  devByteIn, devByteOut;
  logic        devTaken, irqReq;

  int vectors = 0;
  int misses  = 0;

  logic       mReady, mEn;
  logic [7:0] mData;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_dev_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .busHit(busHit), .devSet(devSet), .devLoad(devLoad),
    .devByteIn(devByteIn), .devByteOut(devByteOut), .devTaken(devTaken),
    .irqReq(irqReq)
  );

  function automatic logic inWin(input logic [31:0] a);
    return a[31:16] == 16'hFFFF;
  endfunction

  function automatic logic [31:0] expRdata(input logic [31:0] a, input logic rd);
    if (!rd || !inWin(a)) return 32'h0;
    if (a[15:0] == 16'h0000) return {30'h0, mEn, mReady};
    if (a[15:0] == 16'h0004) return {24'h0, mData};
    return 32'h0;
  endfunction

  function automatic string rdTag(input logic [31:0] a);
    if (!inWin(a)) return "R1";
    if (a[15:0] == 16'h0000) return "R2";
    if (a[15:0] == 16'h0004) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, check outputs, then update the model.
  task automatic cycle(input logic rd, input logic wr, input logic [31:0] a,
                       input logic [31:0] wd, input logic ds, input logic dl,
                       input logic [7:0] db);
    logic acc;
    @(negedge clk);
    busRead = rd; busWrite = wr; busAddr = a; busWdata = wd;
    devSet = ds; devLoad = dl; devByteIn = db;
    #1;
    acc = inWin(a) && a[15:0] == 16'h0004 && (rd || wr);
    check("R1 hit", {31'h0, busHit}, {31'h0, inWin(a) && (rd || wr)});
    check(rdTag(a), busRdata, expRdata(a, rd));
    check("R4 taken", {31'h0, devTaken}, {31'h0, acc});
    check("R7 irq", {31'h0, irqReq}, {31'h0, mReady && mEn});
    check("R8 out", {24'h0, devByteOut}, {24'h0, mData});
    @(posedge clk);
    if (rstN) begin
      if (ds && dl) mData = db;
      else if (acc && wr) mData = wd[7:0];
      if (ds) mReady = 1'b1;
      else if (acc) mReady = 1'b0;
      if (inWin(a) && a[15:0] == 16'h0000 && wr) mEn = wd[1];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rstN = 1'b0; busRead = 0; busWrite = 0; busAddr = 0; busWdata = 0;
    devSet = 0; devLoad = 0; devByteIn = 0;
    mReady = 0; mEn = 0; mData = 0;
    // R10: set state during reset must not stick
    cycle(0, 0, 0, 0, 1, 1, 8'h5A);
    cycle(0, 0, 0, 0, 0, 0, 8'h00);
    rstN = 1'b1;
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);   // R10 status reads zero
    cycle(1, 0, 32'hFFFF_0004, 0, 0, 0, 0);   // R10 data reads zero

    // R3 device loads a byte and sets ready; R2 polling leaves it set
    cycle(0, 0, 0, 0, 1, 1, 8'hA5);
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);
    // R4 data read clears ready
    cycle(1, 0, 32'hFFFF_0004, 0, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);
    // R6 enable via write, bit0 ignored; R7 interrupt follows ready
    cycle(0, 1, 32'hFFFF_0000, 32'h3, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 0, 0);
    cycle(1, 0, 32'hFFFF_0000, 0, 0, 0, 0);
    // R5 collision of device strobe and data store keeps ready; R8 device byte wins
    cycle(0, 1, 32'hFFFF_0004, 32'h77, 1, 1, 8'h3C);
    cycle(1, 0, 32'hFFFF_0004, 0, 0, 0, 0);
    // R4 store clears ready, R8 stores byte
    cycle(0, 1, 32'hFFFF_0004, 32'hDEAD_BE12, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0004, 0, 0, 0, 0);
    // R9 unused offset, R1 below window
    cycle(0, 1, 32'hFFFF_0008, 32'hFF, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0008, 0, 0, 0, 0);
    cycle(0, 1, 32'hFFFE_0004, 32'h99, 0, 0, 0);
    cycle(0, 1, 32'hFFFE_0000, 32'h0, 0, 0, 0);
    cycle(1, 0, 32'hFFFE_0004, 0, 0, 0, 0);
    cycle(1, 0, 32'hFFFF_0004, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      int op, pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = 32'hFFFF_0000;
        3, 4, 5: a = 32'hFFFF_0004;
        6:       a = 32'hFFFF_0000 | {16'h0, 14'($urandom), 2'b00};
        7:       a = 32'hFFFE_0004;
        default: a = $urandom;
      endcase
      op = $urandom_range(0, 2);
      cycle(op == 1, op == 2, a, $urandom, $urandom_range(0, 3) == 0,
            1'($urandom), 8'($urandom));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule